// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one burst request into the stream of column addresses that the burst visits, one address per clock. A request is a single-cycle start strobe carrying a 9-bit starting column, a 3-bit burst-length code and an ordering bit. From the cycle after the strobe, the block presents one column per cycle with a valid flag. A last-beat flag marks the final column. A controller uses it to issue column accesses of a burst without computing the wrap and ordering rules itself.

Fixed-length bursts of 1, 2, 4 or 8 beats stay inside an aligned group of columns the size of the burst. The low column bits pick the first beat and the address wraps back inside the group. The upper bits never change during the burst. Beats can follow one of two orders: an incrementing order or an XOR order. A page-mode burst walks every column of the 512-column page, wraps from the top column back to column 0, and runs until a terminate input ends it. A length code that is not supported, or page mode combined with the XOR order, raises an error flag, and the request then yields a single beat.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held, and while no burst is active, `valid_o`, `last_o` and `cfg_err_o` are 0 and `col_o` is 0.
- R2: A start strobe sampled on a clock edge makes `valid_o` high in the following cycle, with `col_o` showing the first beat (the starting column). `valid_o` then stays high for one beat per cycle until the last beat.
- R3: Length codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. `last_o` is high only on the final beat, and `valid_o` is low in the cycle after it unless a new strobe arrived.
- R4: With `ilv_i` = 0 and length L = 2^code, beat b has column bits above log2(L) equal to those of the start column. Its low log2(L) bits are (start low bits + b) mod L.
- R5: With `ilv_i` = 1 and length L = 2^code, beat b keeps the upper bits of the start column. Its low log2(L) bits are (start low bits) XOR b.
- R6: Length code 7 with `ilv_i` = 0 is page mode. Beat b is at column (start + b) mod 512. The burst runs for any number of beats. `last_o` is high in the cycle in which `term_i` is high, and `valid_o` is low in the next cycle.
- R7: `term_i` has no effect during a fixed-length burst: the burst keeps its full length and its columns.
- R8: Length codes 4, 5 and 6, and code 7 with `ilv_i` = 1, give exactly one beat at the start column. That beat has `last_o` = 1 and `cfg_err_o` = 1. `cfg_err_o` is 0 on every beat of a valid request.
- R9: A start strobe during an active burst abandons that burst. The next cycle shows beat 0 of the new request, using its column, length and order.
- R10: With no burst active, `term_i` has no effect and `valid_o` stays low until a start strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe for a new burst |
| start_col_i | input | 9 | Starting column, sampled with the strobe |
| blen_code_i | input | 3 | Burst-length code: 0..3 give 1/2/4/8 beats, 7 gives page mode, 4..6 are reserved |
| ilv_i | input | 1 | Beat order: 0 incrementing, 1 XOR |
| term_i | input | 1 | Ends a page-mode burst on the current beat |
| col_o | output | 9 | Column of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Current beat is the final one |
| cfg_err_o | output | 1 | Current single beat comes from an unsupported request |

## Verification
The stimulus that is hardest to reach from the ports is the wrap cases. Each fixed-length ordering has to be seen from every starting offset in every aligned group. A page-mode burst also has to cross from column 511 back to column 0 and then be stopped at an arbitrary beat. The bench therefore sweeps all 512 start columns for every valid length code and both orders, toggling `term_i` along the way. It runs page bursts of several lengths from starts near the top of the page, plus one burst longer than a full page. Separate short sequences cover the reserved codes and a restart during a burst.

// File: rtl/burst_col_pkg.sv
// Shared constants and the decoded burst configuration type.
// Assumes column widths up to 15 bits (LG_W holds log2 of the burst length).
package burst_col_pkg;
    localparam int BL_CODE_W = 3;
    localparam int LG_W      = 4;
    localparam logic [BL_CODE_W-1:0] BL_CODE_MAX_FIXED = 3'd3;
    localparam logic [BL_CODE_W-1:0] BL_CODE_PAGE      = 3'd7;

    typedef struct packed {
        logic [LG_W-1:0] lg_len;   // log2 of wrap-group size
        logic            page;     // page mode, ends only on terminate
        logic            ilv;      // XOR beat order
        logic            err;      // unsupported request, single beat
    } burst_cfg_t;
endpackage

// File: rtl/burst_cfg_decode.sv
// Decodes the length code and order bit into a burst configuration.
// Assumes: codes 0..3 are fixed lengths, 7 is page mode (incrementing only),
// everything else is reported as an error and treated as a one-beat burst.
module burst_cfg_decode
    import burst_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [BL_CODE_W-1:0] code_i,
    input  logic                 ilv_i,
    output burst_cfg_t           cfg_o
);
    // Map the request onto group size, mode and error flag.
    always_comb begin
        cfg_o = '0;
        if (code_i <= BL_CODE_MAX_FIXED) begin
            cfg_o.lg_len = LG_W'(code_i);
            cfg_o.ilv    = ilv_i;
        end else if (code_i == BL_CODE_PAGE && !ilv_i) begin
            cfg_o.lg_len = LG_W'(COL_W);
            cfg_o.page   = 1'b1;
        end else begin
            cfg_o.err    = 1'b1;
        end
    end
endmodule

// File: rtl/burst_seq.sv
// Burst sequencer: holds the captured request and counts beats.
// Assumes a start strobe always wins over ending or advancing a burst.
module burst_seq
    import burst_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  burst_cfg_t       cfg_i,
    input  logic             term_i,
    output logic             active_o,
    output logic [COL_W-1:0] beat_o,
    output logic [COL_W-1:0] base_col_o,
    output burst_cfg_t       cfg_o,
    output logic             last_o
);
    logic             active_q;
    logic [COL_W-1:0] beat_q;
    logic [COL_W-1:0] base_q;
    burst_cfg_t       cfg_q;
    logic [COL_W-1:0] final_beat;
    logic             is_last;

    // Index of the final beat for a fixed-length burst.
    always_comb final_beat = COL_W'((32'd1 << cfg_q.lg_len) - 32'd1);

    // Page mode ends on terminate; fixed lengths end on the final index.
    always_comb is_last = cfg_q.page ? term_i : (beat_q == final_beat);

    // Capture a request, advance the beat, or close the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            beat_q   <= '0;
            base_q   <= '0;
            cfg_q    <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            beat_q   <= '0;
            base_q   <= start_col_i;
            cfg_q    <= cfg_i;
        end else if (active_q && is_last) begin
            active_q <= 1'b0;
        end else if (active_q) begin
            beat_q   <= beat_q + 1'b1;
        end
    end

    assign active_o   = active_q;
    assign beat_o     = beat_q;
    assign base_col_o = base_q;
    assign cfg_o      = cfg_q;
    assign last_o     = active_q && is_last;
endmodule

// File: rtl/burst_col_map.sv
// Column mapper: combines the start column and beat index into a column.
// Bits at and above lg_len come from the start column; the bits below wrap
// inside the aligned group using either addition or XOR.
module burst_col_map
    import burst_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base_col_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [LG_W-1:0]  lg_len_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] wrap_mask;
    logic [COL_W-1:0] moved;

    // One mask bit per column bit that lies inside the wrap group.
    for (genvar i = 0; i < COL_W; i++) begin : g_mask
        assign wrap_mask[i] = (LG_W'(i) < lg_len_i);
    end

    // Pick the beat order, then splice the group bits into the start column.
    always_comb begin
        moved = ilv_i ? (base_col_i ^ beat_i) : (base_col_i + beat_i);
        col_o = (base_col_i & ~wrap_mask) | (moved & wrap_mask);
    end
endmodule

// File: rtl/burst_col_gen.sv
// Top level: SDRAM burst column address generator.
// One column per clock, starting the cycle after the start strobe.
// Outputs are forced to zero while no burst is active.
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [COL_W-1:0]     start_col_i,
    input  logic [BL_CODE_W-1:0] blen_code_i,
    input  logic                 ilv_i,
    input  logic                 term_i,
    output logic [COL_W-1:0]     col_o,
    output logic                 valid_o,
    output logic                 last_o,
    output logic                 cfg_err_o
);
    burst_cfg_t       req_cfg;
    burst_cfg_t       seq_cfg;
    logic             active;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] base_col;
    logic [COL_W-1:0] mapped_col;
    logic             seq_last;

    burst_cfg_decode #(.COL_W(COL_W)) u_decode (
        .code_i (blen_code_i),
        .ilv_i  (ilv_i),
        .cfg_o  (req_cfg)
    );

    burst_seq #(.COL_W(COL_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .cfg_i       (req_cfg),
        .term_i      (term_i),
        .active_o    (active),
        .beat_o      (beat),
        .base_col_o  (base_col),
        .cfg_o       (seq_cfg),
        .last_o      (seq_last)
    );

    burst_col_map #(.COL_W(COL_W)) u_map (
        .base_col_i (base_col),
        .beat_i     (beat),
        .lg_len_i   (seq_cfg.lg_len),
        .ilv_i      (seq_cfg.ilv),
        .col_o      (mapped_col)
    );

    // Drive outputs only while a burst is in progress.
    always_comb begin
        valid_o   = active;
        col_o     = active ? mapped_col : '0;
        last_o    = seq_last;
        cfg_err_o = active && seq_cfg.err;
    end
endmodule

// File: rtl/burst_col_gen_chk.sv
// Checker for burst_col_gen: port-level protocol rules, plus the page-mode
// step rule using the captured mode bit. Attached by the bind below.
module burst_col_gen_chk #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o,
    input logic             cfg_err_o,
    input logic             page_mode
);
    // R1: idle outputs are quiet
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (!last_o && !cfg_err_o && col_o == '0));

    // R2: a strobe yields a beat next cycle
    a_r2_start_beat: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> valid_o);

    // R2: no gap inside a burst
    a_r2_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o && !start_i) |=> valid_o);

    // R3: the burst closes after its last beat
    a_r3_close_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && last_o && !start_i) |=> !valid_o);

    // R6: page mode steps by one column with wrap
    a_r6_page_step: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && page_mode && !last_o && !start_i) |=>
            (col_o == COL_W'($past(col_o) + 1'b1)));

    // R8: an error beat is a single beat
    a_r8_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> (valid_o && last_o));

    // R10: idle persists without a strobe
    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && !start_i) |=> !valid_o);
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .col_o     (col_o),
    .valid_o   (valid_o),
    .last_o    (last_o),
    .cfg_err_o (cfg_err_o),
    .page_mode (seq_cfg.page)
);

// File: tb/burst_col_gen_tb.sv
// Sweep bench: every start column for every fixed length and order, page
// bursts across the page wrap, reserved codes and a restart mid-burst.
module burst_col_gen_tb;
    localparam int COL_W = 9;
    localparam int PAGE  = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       blen_code_i = '0;
    logic             ilv_i = 1'b0;
    logic             term_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o;
    logic             last_o;
    logic             cfg_err_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    burst_col_gen #(.COL_W(COL_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .blen_code_i (blen_code_i),
        .ilv_i       (ilv_i),
        .term_i      (term_i),
        .col_o       (col_o),
        .valid_o     (valid_o),
        .last_o      (last_o),
        .cfg_err_o   (cfg_err_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected column from group base and offset arithmetic.
    function automatic int exp_col(int s, int code, int ilv, int b);
        int len, base, off;
        if (code == 7) return (s + b) % PAGE;
        len  = 1 << code;
        off  = s % len;
        base = s - off;
        if (ilv != 0) return base + (off ^ b);
        return base + ((off + b) % len);
    endfunction

    task automatic check_idle(input string tag);
        #1;
        chk({tag, " valid"}, int'(valid_o), 0);
        chk({tag, " last"},  int'(last_o), 0);
        chk({tag, " err"},   int'(cfg_err_o), 0);
        chk({tag, " col"},   int'(col_o), 0);
    endtask

    task automatic launch(input int s, input int code, input int ilv);
        @(negedge clk);
        start_i     = 1'b1;
        start_col_i = COL_W'(s);
        blen_code_i = 3'(code);
        ilv_i       = ilv[0];
        @(negedge clk);
        start_i     = 1'b0;
        start_col_i = '0;
    endtask

    // R2 R3 R4 R5 R7: fixed burst, optional terminate noise
    task automatic fixed_burst(input int s, input int code, input int ilv, input bit noise);
        int len = 1 << code;
        launch(s, code, ilv);
        for (int b = 0; b < len; b++) begin
            term_i = noise;
            #1;
            chk(ilv != 0 ? "R5 col" : "R4 col", int'(col_o), exp_col(s, code, ilv, b));
            chk("R2 valid", int'(valid_o), 1);
            chk("R3 R7 last", int'(last_o), int'(b == len - 1));
            chk("R8 err", int'(cfg_err_o), 0);
            @(negedge clk);
        end
        term_i = 1'b0;
        #1;
        chk("R3 valid after last", int'(valid_o), 0);
    endtask

    // R6: page burst terminated on beat n-1
    task automatic page_burst(input int s, input int n);
        launch(s, 7, 0);
        for (int b = 0; b < n; b++) begin
            term_i = (b == n - 1);
            #1;
            chk("R6 col", int'(col_o), (s + b) % PAGE);
            chk("R6 valid", int'(valid_o), 1);
            chk("R6 last", int'(last_o), int'(b == n - 1));
            @(negedge clk);
        end
        term_i = 1'b0;
        #1;
        chk("R6 valid after term", int'(valid_o), 0);
    endtask

    // R8: unsupported request gives one flagged beat
    task automatic err_burst(input int s, input int code, input int ilv);
        launch(s, code, ilv);
        #1;
        chk("R8 col", int'(col_o), s);
        chk("R8 valid", int'(valid_o), 1);
        chk("R8 last", int'(last_o), 1);
        chk("R8 err", int'(cfg_err_o), 1);
        @(negedge clk);
        #1;
        chk("R8 single beat", int'(valid_o), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check_idle("R1 in reset");
        rst_n = 1'b1;
        check_idle("R1 after reset");

        // R10: terminate while idle does nothing
        term_i = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check_idle("R10 idle term");
        end
        term_i = 1'b0;

        // R4 R5 R3 R7: full sweep of fixed lengths
        for (int code = 0; code < 4; code++)
            for (int ilv = 0; ilv < 2; ilv++)
                for (int s = 0; s < PAGE; s++)
                    fixed_burst(s, code, ilv, s[0]);

        // R6: page mode with wrap across column 511
        page_burst(0, 1);
        page_burst(5, 3);
        page_burst(510, 9);
        page_burst(511, 3);
        page_burst(300, 600);

        // R8: reserved codes and XOR page mode
        for (int code = 4; code < 7; code++)
            for (int ilv = 0; ilv < 2; ilv++) begin
                err_burst(0, code, ilv);
                err_burst(255, code, ilv);
            end
        err_burst(511, 7, 1);
        err_burst(1, 7, 1);

        // R9: restart an 8-beat burst on its third beat
        launch(10, 3, 0);
        for (int b = 0; b < 3; b++) begin
            #1;
            chk("R9 first col", int'(col_o), exp_col(10, 3, 0, b));
            if (b < 2) @(negedge clk);
        end
        start_i = 1'b1;
        start_col_i = 9'd101;
        blen_code_i = 3'd2;
        ilv_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int b = 0; b < 4; b++) begin
            #1;
            chk("R9 new col", int'(col_o), exp_col(101, 2, 1, b));
            chk("R9 last", int'(last_o), int'(b == 3));
            @(negedge clk);
        end
        #1;
        chk("R9 valid after", int'(valid_o), 0);
        check_idle("R1 idle end");

        finish_run();
    end
endmodule